// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one memory-to-memory DMA channel driven by a chain of transfer descriptors that sit in memory. Software places one or more descriptors in memory, writes the address of the first into the current-descriptor register, and then writes the mode register with the start bit set. The channel reads each descriptor and copies the stated number of bytes from its source to its destination, one bus word at a time. It then follows the next-link field to the next descriptor. It stops after the descriptor whose link field carries the end-of-list flag.

A descriptor takes four bus words from a 32-byte-aligned base, at word offsets 0, 1, 2 and 3: source byte address, destination byte address, next link (bit 0 is the end-of-list flag; bits 4..0 are dropped when the link is used as an address) and byte count. The status register shows the busy and halted states beside sticky event bits for end of segment, end of chain descriptor, end of list, programming error and transfer error. One interrupt line combines the event bits with their enables in the mode register. Software can stop the channel with the abort bit, and writing zero to the mode register returns the whole channel to its reset state.

The register port is one write strobe with a word index and a combinational read mux. The memory port issues one word access at a time and holds it until the memory acknowledges it. An error flag that comes with the acknowledge marks a failed access.

Top module: `dchain_dma`

## Requirements
- R1: The registers are at word index 0 mode, 1 status, 2 current descriptor address, 3 next link, 4 remaining byte count. A write to the current descriptor address while the channel is idle is stored with bits 4..0 forced to zero. A mode write with bit 0 (start) set and bit 1 (abort) clear, made while the channel is not busy, makes status bit 0 (busy) read 1 from the next cycle. The first memory access is then a read of that aligned address.
- R2: For each descriptor the channel reads its source, destination, link and count words at aligned base + 0, 4, 8 and 12. It then copies count/4 words in ascending order, each from the source to the destination. The low two bits of the count are ignored, and no word beyond the count is written.
- R3: A link word with bit 0 clear makes the channel fetch the next descriptor at the link with bits 4..0 cleared. After the descriptor whose link has bit 0 set, the channel stops with busy 0 and halted (status bit 1) 0, and sets status bit 3 (end of list).
- R4: Status bit 2 (end of segment) is set when each descriptor finishes. Status bit 4 (end of chain descriptor) is set when a descriptor with the end-of-list flag and a nonzero count has been loaded.
- R5: A descriptor whose count is zero after the low two bits are dropped sets status bit 5 (programming error) and stops the channel with halted 1 and busy 0. The byte-count register then reads 0, and no destination word is written.
- R6: A memory acknowledge that comes with the error flag sets status bit 7 (transfer error) and stops the channel with halted 1 and busy 0.
- R7: While busy, a mode write with bit 1 (abort) set stops the channel within one cycle after the write, with busy 0 and halted 1. Clearing start and abort later keeps the channel idle and halted. The next launch clears halted.
- R8: Status bits 2, 3, 4, 5 and 7 are cleared by writing 1 to them, and writing 0 to them has no effect. Busy and halted are read-only.
- R9: The irq output is 1 exactly when one of these pairs is set: an error bit (5 or 7) with mode bit 4, end of segment with mode bit 5, end of list with mode bit 6, or end of chain descriptor with mode bit 7.
- R10: A mode write of zero returns the channel to idle. Mode, status, current descriptor address, next link and byte count all read 0 afterwards, and irq is 0.
- R11: The next-link register reads the raw link word of the descriptor in progress. The byte-count register reads the bytes still left to copy in it, a multiple of 4.
- R12: A memory request that has not been acknowledged stays asserted with its address and direction unchanged until it is acknowledged, unless the channel is aborted or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | RW (32) | Register write data |
| reg_rdata | output | RW (32) | Register read data for reg_idx |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (32) | Byte address of the word |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted |
| mem_err | input | 1 | Access failed, valid with mem_ack |

## Verification
A wrong descriptor word index or a wrong link alignment sends the channel to the wrong address on its first fetch. The result is a wrong or missing destination word and a wrong next-link readback once the chain ends. A count or end-of-list flag that is not tracked properly shows as one word too many or too few at the destination guard word, or as a channel that stays busy. That is caught within a few hundred cycles of the launch. A lost event or a lost enable shows in the status word and on irq one cycle after the channel falls idle. Abort and error paths show as the halted bit read back within two cycles.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

   localparam int RIDX_W = 3;

   localparam logic [RIDX_W-1:0] RIDX_MODE = 3'd0;
   localparam logic [RIDX_W-1:0] RIDX_STAT = 3'd1;
   localparam logic [RIDX_W-1:0] RIDX_CDAR = 3'd2;
   localparam logic [RIDX_W-1:0] RIDX_NLNK = 3'd3;
   localparam logic [RIDX_W-1:0] RIDX_BCNT = 3'd4;

   localparam int MODE_W    = 8;
   localparam int MB_START  = 0;
   localparam int MB_ABORT  = 1;
   localparam int MB_ERR_IE = 4;
   localparam int MB_EOS_IE = 5;
   localparam int MB_EOL_IE = 6;
   localparam int MB_ECD_IE = 7;

   localparam int SB_BUSY = 0;
   localparam int SB_HALT = 1;
   localparam int SB_EOS  = 2;
   localparam int SB_EOL  = 3;
   localparam int SB_ECD  = 4;
   localparam int SB_PE   = 5;
   localparam int SB_TE   = 7;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_READ  = 2'd2,
      ST_WRITE = 2'd3
   } eng_state_t;

   typedef struct packed {
      logic te;
      logic pe;
      logic ecd;
      logic eol;
      logic eos;
   } evt_t;

endpackage

// File: rtl/dchain_engine.sv
module dchain_engine
   import dchain_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CW       = 16,
   parameter int ALIGN_LG = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst_i,
   input  logic          launch_i,
   input  logic          abort_i,
   input  logic          cdar_we_i,
   input  logic [AW-1:0] cdar_wdata_i,
   output logic          busy_o,
   output logic          halted_o,
   output evt_t          evt_o,
   output logic [AW-1:0] cdar_o,
   output logic [AW-1:0] nlnk_o,
   output logic [CW-1:0] bcnt_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   input  logic          mem_err_i
);

   localparam int WB    = DW / 8;
   localparam int WB_LG = $clog2(WB);
   localparam int IDX_W = 2;
   localparam logic [CW-1:0] CNT_STEP = CW'(WB);
   localparam logic [CW-1:0] CNT_MASK = ~CW'(WB - 1);

   if (DW < AW) begin : g_bad_dw
      $error("dchain_engine: DW must be at least AW");
   end
   if (CW > DW) begin : g_bad_cw
      $error("dchain_engine: CW must not exceed DW");
   end
   if ((4 * WB) > (2 ** ALIGN_LG)) begin : g_bad_align
      $error("dchain_engine: descriptor does not fit its alignment");
   end

   eng_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [AW-1:0]    cdar_q, src_q, dst_q, nlnk_q;
   logic [CW-1:0]    bcnt_q;
   logic [DW-1:0]    buf_q;
   logic             halted_q;
   evt_t             evt_q;
   logic [CW-1:0]    cnt_in;
   logic [AW-1:0]    fetch_addr;

   function automatic logic [AW-1:0] align_f(input logic [AW-1:0] a);
      return {a[AW-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
   endfunction

   assign cnt_in     = mem_rdata_i[CW-1:0] & CNT_MASK;
   assign fetch_addr = cdar_q + AW'({idx_q, {WB_LG{1'b0}}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         cdar_q   <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         nlnk_q   <= '0;
         bcnt_q   <= '0;
         buf_q    <= '0;
         halted_q <= 1'b0;
         evt_q    <= '0;
      end else if (soft_rst_i) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         cdar_q   <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         nlnk_q   <= '0;
         bcnt_q   <= '0;
         buf_q    <= '0;
         halted_q <= 1'b0;
         evt_q    <= '0;
      end else begin
         evt_q <= '0;
         if (state_q == ST_IDLE) begin
            if (cdar_we_i) begin
               cdar_q <= align_f(cdar_wdata_i);
            end
            if (launch_i) begin
               halted_q <= 1'b0;
               idx_q    <= '0;
               state_q  <= ST_FETCH;
            end
         end else if (abort_i) begin
            state_q  <= ST_IDLE;
            halted_q <= 1'b1;
         end else if (mem_ack_i) begin
            if (mem_err_i) begin
               evt_q.te <= 1'b1;
               halted_q <= 1'b1;
               state_q  <= ST_IDLE;
            end else begin
               unique case (state_q)
                  ST_FETCH: begin
                     idx_q <= idx_q + 1'b1;
                     unique case (idx_q)
                        2'd0: src_q  <= mem_rdata_i[AW-1:0];
                        2'd1: dst_q  <= mem_rdata_i[AW-1:0];
                        2'd2: nlnk_q <= mem_rdata_i[AW-1:0];
                        default: begin
                           bcnt_q <= cnt_in;
                           if (cnt_in == '0) begin
                              evt_q.pe <= 1'b1;
                              halted_q <= 1'b1;
                              state_q  <= ST_IDLE;
                           end else begin
                              evt_q.ecd <= nlnk_q[0];
                              state_q   <= ST_READ;
                           end
                        end
                     endcase
                  end
                  ST_READ: begin
                     buf_q   <= mem_rdata_i;
                     state_q <= ST_WRITE;
                  end
                  ST_WRITE: begin
                     src_q  <= src_q + AW'(WB);
                     dst_q  <= dst_q + AW'(WB);
                     bcnt_q <= bcnt_q - CNT_STEP;
                     if (bcnt_q == CNT_STEP) begin
                        evt_q.eos <= 1'b1;
                        if (nlnk_q[0]) begin
                           evt_q.eol <= 1'b1;
                           state_q   <= ST_IDLE;
                        end else begin
                           cdar_q  <= align_f(nlnk_q);
                           idx_q   <= '0;
                           state_q <= ST_FETCH;
                        end
                     end else begin
                        state_q <= ST_READ;
                     end
                  end
                  default: state_q <= ST_IDLE;
               endcase
            end
         end
      end
   end

   always_comb begin
      mem_req_o = (state_q != ST_IDLE);
      mem_we_o  = (state_q == ST_WRITE);
      unique case (state_q)
         ST_FETCH: mem_addr_o = fetch_addr;
         ST_READ:  mem_addr_o = src_q;
         ST_WRITE: mem_addr_o = dst_q;
         default:  mem_addr_o = cdar_q;
      endcase
   end

   assign mem_wdata_o = buf_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign halted_o    = halted_q;
   assign evt_o       = evt_q;
   assign cdar_o      = cdar_q;
   assign nlnk_o      = nlnk_q;
   assign bcnt_o      = bcnt_q;

   assert_launch_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      launch_i && !soft_rst_i |=> busy_o && mem_addr_o[ALIGN_LG-1:0] == '0 && !mem_we_o);

   assert_end_of_list_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.eol |-> !busy_o && !halted_o && evt_o.eos);

   assert_ecd_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.ecd |-> busy_o && bcnt_o != '0);

   assert_pe_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.pe |-> !busy_o && halted_o && bcnt_o == '0);

   assert_te_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.te |-> !busy_o && halted_o);

   assert_abort_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i && busy_o && !soft_rst_i |=> !busy_o && halted_o);

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i && !abort_i && !soft_rst_i
      |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

endmodule

// File: rtl/dchain_regs.sv
module dchain_regs
   import dchain_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 16,
   parameter int RW      = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RIDX_W-1:0] reg_idx,
   input  logic [RW-1:0]     reg_wdata,
   output logic [RW-1:0]     reg_rdata,
   output logic              irq_o,
   input  logic              busy_i,
   input  logic              halted_i,
   input  evt_t              evt_i,
   input  logic [AW-1:0]     cdar_i,
   input  logic [AW-1:0]     nlnk_i,
   input  logic [CW-1:0]     bcnt_i,
   output logic              launch_o,
   output logic              abort_o,
   output logic              soft_rst_o,
   output logic              cdar_we_o,
   output logic [AW-1:0]     cdar_wdata_o
);

   if (AW > RW) begin : g_bad_aw
      $error("dchain_regs: AW must not exceed RW");
   end
   if (CW > RW || MODE_W > RW) begin : g_bad_rw
      $error("dchain_regs: register width too small");
   end

   logic [MODE_W-1:0] mode_q;
   evt_t              ev_q;
   evt_t              clr;
   logic              mode_wr, stat_wr;
   logic [7:0]        stat_word;
   logic              irq_raw;

   assign mode_wr      = reg_we && (reg_idx == RIDX_MODE);
   assign stat_wr      = reg_we && (reg_idx == RIDX_STAT);
   assign soft_rst_o   = mode_wr && (reg_wdata == '0);
   assign launch_o     = mode_wr && reg_wdata[MB_START] && !reg_wdata[MB_ABORT] && !busy_i;
   assign abort_o      = mode_q[MB_ABORT];
   assign cdar_we_o    = reg_we && (reg_idx == RIDX_CDAR) && !busy_i;
   assign cdar_wdata_o = reg_wdata[AW-1:0];

   always_comb begin
      clr     = '0;
      clr.eos = stat_wr && reg_wdata[SB_EOS];
      clr.eol = stat_wr && reg_wdata[SB_EOL];
      clr.ecd = stat_wr && reg_wdata[SB_ECD];
      clr.pe  = stat_wr && reg_wdata[SB_PE];
      clr.te  = stat_wr && reg_wdata[SB_TE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ev_q   <= '0;
      end else if (soft_rst_o) begin
         mode_q <= '0;
         ev_q   <= '0;
      end else begin
         if (mode_wr) begin
            mode_q <= reg_wdata[MODE_W-1:0];
         end
         ev_q <= evt_i | (ev_q & ~clr);
      end
   end

   assign stat_word = {ev_q.te, 1'b0, ev_q.pe, ev_q.ecd, ev_q.eol, ev_q.eos, halted_i, busy_i};

   always_comb begin
      unique case (reg_idx)
         RIDX_MODE: reg_rdata = RW'(mode_q);
         RIDX_STAT: reg_rdata = RW'(stat_word);
         RIDX_CDAR: reg_rdata = RW'(cdar_i);
         RIDX_NLNK: reg_rdata = RW'(nlnk_i);
         RIDX_BCNT: reg_rdata = RW'(bcnt_i);
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_raw = ((ev_q.te | ev_q.pe) & mode_q[MB_ERR_IE])
                  | (ev_q.eos & mode_q[MB_EOS_IE])
                  | (ev_q.eol & mode_q[MB_EOL_IE])
                  | (ev_q.ecd & mode_q[MB_ECD_IE]);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= irq_raw;
         end
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ev_q == '0 |-> !irq_o);
   end

   assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && reg_wdata[SB_EOS] && !evt_i.eos && !soft_rst_o |=> !ev_q.eos);

   assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_q.eol && !(stat_wr && reg_wdata[SB_EOL]) && !soft_rst_o |=> ev_q.eol);

   assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> ev_q == '0 && mode_q == '0);

endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
   import dchain_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CW       = 16,
   parameter int RW       = 32,
   parameter int ALIGN_LG = 5,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RIDX_W-1:0] reg_idx,
   input  logic [RW-1:0]     reg_wdata,
   output logic [RW-1:0]     reg_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err
);

   logic          busy, halted, launch, abort, soft_rst, cdar_we;
   logic [AW-1:0] cdar_wdata, cdar, nlnk;
   logic [CW-1:0] bcnt;
   evt_t          evt;

   dchain_regs #(
      .AW      (AW),
      .CW      (CW),
      .RW      (RW),
      .IRQ_REG (IRQ_REG)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_idx      (reg_idx),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq_o        (irq),
      .busy_i       (busy),
      .halted_i     (halted),
      .evt_i        (evt),
      .cdar_i       (cdar),
      .nlnk_i       (nlnk),
      .bcnt_i       (bcnt),
      .launch_o     (launch),
      .abort_o      (abort),
      .soft_rst_o   (soft_rst),
      .cdar_we_o    (cdar_we),
      .cdar_wdata_o (cdar_wdata)
   );

   dchain_engine #(
      .AW       (AW),
      .DW       (DW),
      .CW       (CW),
      .ALIGN_LG (ALIGN_LG)
   ) eng_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst_i   (soft_rst),
      .launch_i     (launch),
      .abort_i      (abort),
      .cdar_we_i    (cdar_we),
      .cdar_wdata_i (cdar_wdata),
      .busy_o       (busy),
      .halted_o     (halted),
      .evt_o        (evt),
      .cdar_o       (cdar),
      .nlnk_o       (nlnk),
      .bcnt_o       (bcnt),
      .mem_req_o    (mem_req),
      .mem_we_o     (mem_we),
      .mem_addr_o   (mem_addr),
      .mem_wdata_o  (mem_wdata),
      .mem_rdata_i  (mem_rdata),
      .mem_ack_i    (mem_ack),
      .mem_err_i    (mem_err)
   );

endmodule

// File: tb/dchain_dma_tb.sv
module dchain_dma_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DESC_W0    = 'h300;

   // vector: src word base[31:22], dst word base[21:12], words per descriptor[11:4], descriptors[3:0]
   localparam logic [31:0] VEC [4] = '{
      {10'h040, 10'h100, 8'd1, 4'd1},
      {10'h050, 10'h120, 8'd5, 4'd1},
      {10'h080, 10'h160, 8'd3, 4'd4},
      {10'h0C0, 10'h1A0, 8'd8, 4'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        mem_req, mem_we, mem_ack, mem_err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   logic        bd_we = 1'b0;
   logic [9:0]  bd_addr = '0;
   logic [31:0] bd_data = '0;
   logic [31:0] mem [1024];
   logic [7:0]  lfsr = 8'h5B;
   logic        stall_en = 1'b1;
   logic        stall;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dchain_dma dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err)
   );

   always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   assign stall     = stall_en & lfsr[0];
   assign mem_ack   = mem_req & ~stall;
   assign mem_err   = mem_req & mem_addr[12];
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (bd_we) mem[bd_addr] <= bd_data;
      else if (mem_req && mem_we && mem_ack && !mem_addr[12]) mem[mem_addr[11:2]] <= mem_wdata;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic mem_put(input int widx, input logic [31:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_addr = widx[9:0]; bd_data = d;
      @(posedge clk); #1;
      bd_we = 1'b0;
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] d);
      reg_idx = idx; #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      int n = 0;
      s = 32'h1;
      while (s[0] && n < 5000) begin
         @(negedge clk);
         rd(3'd1, s);
         n++;
      end
      if (s[0]) check(req, 32'hFFFF_FFFF, 32'h0);
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] pat(input int e, input int k);
      return 32'hA500_0000 ^ (e << 16) ^ (k * 32'h0000_0101);
   endfunction

   initial begin
      #(CLK_PERIOD * 190000);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [31:0] v;
      int sw, dw, nw, nd, base;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(3'd1, r); check("R10 reset status", r, 32'h0);
      rd(3'd0, r); check("R10 reset mode", r, 32'h0);
      rd(3'd2, r); check("R10 reset cdar", r, 32'h0);
      check("R9 reset irq", {31'h0, irq}, 32'h0);

      for (int e = 0; e < 4; e++) begin
         v  = VEC[e];
         sw = int'(v[31:22]); dw = int'(v[21:12]); nw = int'(v[11:4]); nd = int'(v[3:0]);
         for (int k = 0; k < nw * nd; k++) begin
            mem_put(sw + k, pat(e, k));
            mem_put(dw + k, 32'h0);
         end
         mem_put(dw + nw * nd, 32'h5A5A_5A5A);
         for (int i = 0; i < nd; i++) begin
            base = DESC_W0 + i * 8;
            mem_put(base + 0, (sw + i * nw) * 4);
            mem_put(base + 1, (dw + i * nw) * 4);
            mem_put(base + 2, (i == nd - 1) ? ((DESC_W0 + nd * 8) * 4 + 1) : ((DESC_W0 + (i + 1) * 8) * 4 + 4));
            mem_put(base + 3, nw * 4 + ((e == 1) ? 3 : 0));
         end
         wr(3'd1, 32'hFF);
         wr(3'd2, DESC_W0 * 4 + ((e == 2) ? 32'h13 : 32'h0));
         rd(3'd2, r); check("R1 cdar aligned", r, DESC_W0 * 4);
         wr(3'd0, 32'hF1);
         rd(3'd1, r); check("R1 busy after launch", {31'h0, r[0]}, 32'h1);
         wait_idle("R3 chain completes");
         rd(3'd1, r); check("R3 R4 status after chain", r, 32'h1C);
         check("R9 irq after chain", {31'h0, irq}, 32'h1);
         rd(3'd3, r); check("R11 last link", r, (DESC_W0 + nd * 8) * 4 + 1);
         rd(3'd4, r); check("R11 count drained", r, 32'h0);
         for (int k = 0; k < nw * nd; k++) check("R2 copied word", mem[dw + k], pat(e, k));
         check("R2 guard word untouched", mem[dw + nw * nd], 32'h5A5A_5A5A);
      end

      wr(3'd0, 32'h40);
      rd(3'd1, r); check("R9 no launch without start", {31'h0, r[0]}, 32'h0);
      check("R9 eol enable", {31'h0, irq}, 32'h1);
      wr(3'd1, 32'h08);
      rd(3'd1, r); check("R8 clear eol only", r, 32'h14);
      check("R9 masked events", {31'h0, irq}, 32'h0);
      wr(3'd1, 32'h03);
      rd(3'd1, r); check("R8 busy halted read-only", r, 32'h14);
      wr(3'd1, 32'h00);
      rd(3'd1, r); check("R8 zero write no effect", r, 32'h14);
      wr(3'd1, 32'hFF);

      mem_put('h1C0, 32'hDEAD_BEEF);
      mem_put('h380, 32'h100);
      mem_put('h381, 32'h700);
      mem_put('h382, 32'h1);
      mem_put('h383, 32'h3);
      wr(3'd2, 32'hE00);
      wr(3'd0, 32'h11);
      wait_idle("R5 zero count stops");
      rd(3'd1, r); check("R5 programming error status", r, 32'h22);
      rd(3'd4, r); check("R5 count reads zero", r, 32'h0);
      check("R5 no destination write", mem['h1C0], 32'hDEAD_BEEF);
      check("R9 error irq", {31'h0, irq}, 32'h1);
      wr(3'd1, 32'hFF);
      rd(3'd1, r); check("R8 halted survives clear", r, 32'h02);
      check("R9 irq after clear", {31'h0, irq}, 32'h0);

      mem_put('h3A0, 32'h1000);
      mem_put('h3A1, 32'h700);
      mem_put('h3A2, 32'hEA0);
      mem_put('h3A3, 32'h8);
      wr(3'd2, 32'hE80);
      wr(3'd0, 32'h11);
      wait_idle("R6 error stops");
      rd(3'd1, r); check("R6 transfer error status", r, 32'h82);
      check("R6 error irq", {31'h0, irq}, 32'h1);
      wr(3'd1, 32'hFF);

      for (int k = 0; k < 48; k++) mem_put('h200 + k, pat(9, k));
      mem_put('h240 + 47, 32'h0);
      mem_put('h3C0, 32'h800);
      mem_put('h3C1, 32'h900);
      mem_put('h3C2, 32'h0000_0F21);
      mem_put('h3C3, 32'd192);
      wr(3'd2, 32'hF00);
      wr(3'd0, 32'h01);
      repeat (20) @(negedge clk);
      rd(3'd1, r); check("R11 still busy", {31'h0, r[0]}, 32'h1);
      rd(3'd3, r); check("R11 link of current", r, 32'h0000_0F21);
      rd(3'd4, r);
      check("R11 count partial", {31'h0, (r != 0) && (r < 192) && (r[1:0] == 2'b00)}, 32'h1);
      wr(3'd0, 32'h03);
      @(posedge clk); #1;
      rd(3'd1, r); check("R7 abort halts", r[1:0], 32'h2);
      wr(3'd0, 32'h10);
      repeat (3) @(negedge clk);
      rd(3'd1, r); check("R7 stays halted idle", r[1:0], 32'h2);
      check("R7 copy cut short", mem['h240 + 47], 32'h0);

      stall_en = 1'b0;
      v = VEC[0];
      mem_put('h100, 32'h0);
      mem_put(DESC_W0 + 0, 32'h100);
      mem_put(DESC_W0 + 1, 32'h400);
      mem_put(DESC_W0 + 2, 32'h1);
      mem_put(DESC_W0 + 3, 32'h4);
      wr(3'd1, 32'hFF);
      wr(3'd2, DESC_W0 * 4);
      wr(3'd0, 32'hF1);
      wait_idle("R7 relaunch completes");
      rd(3'd1, r); check("R7 relaunch clears halted", r, 32'h1C);
      check("R12 copy without stall", mem['h100], pat(0, 0));

      wr(3'd0, 32'h0);
      rd(3'd1, r); check("R10 soft reset status", r, 32'h0);
      rd(3'd0, r); check("R10 soft reset mode", r, 32'h0);
      rd(3'd2, r); check("R10 soft reset cdar", r, 32'h0);
      rd(3'd3, r); check("R10 soft reset link", r, 32'h0);
      rd(3'd4, r); check("R10 soft reset count", r, 32'h0);
      check("R10 soft reset irq", {31'h0, irq}, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule